// File: doc/BRIEF.md
# Hardware Resource Lock Register

This block is a memory-mapped hardware semaphore that lets several processor cores take turns on a piece of shared state. It holds one lock. The lock is either free or held by a single owner, which is named by a 3-bit identifier. The block sits behind a plain single-cycle register port with three word offsets: one for claiming the lock, one for giving it up, and one for reading back its state.

To claim the lock, a core writes a word to the claim offset. The word carries the core's identifier in bits 31:29 and the request flag in bit 28. The core then reads the state word. It holds the lock only if the identifier field of that word matches its own identifier. If the field does not match, the core writes the claim offset again. To give up the lock, the core writes the same kind of word to the release offset. The lock has no test-and-set read: reads never change the lock state.

Each identifier value from 0 to 7 is a legal owner. Identifier 0 holding the lock is told apart from a free lock by the held flag in bit 28.

Top module: `hwlock_reg`

## Requirements
- R1: After reset the lock is free, and the read data reads as 0x00000000.
- R2: A write to the claim offset (byte address 0x0) with bit 28 set, while the lock is free, makes the identifier in bits 31:29 the owner and sets the held flag.
- R3: A claim write while the lock is held leaves the owner and the held flag unchanged. This holds whether the identifier in the write differs from the owner or matches it.
- R4: A claim write with bit 28 clear has no effect on the lock.
- R5: A write to the release offset (byte address 0x4) with bit 28 set and an identifier equal to the current owner frees the lock. After it, the state word reads as zero.
- R6: A release write while the lock is held has no effect if its identifier differs from the owner or if bit 28 is clear.
- R7: Every identifier from 0 to 7 can claim the lock and then release it. With identifier 0 as owner, the state word reads 0x10000000.
- R8: A read strobe at the state offset (byte address 0x8) loads the read data in the next cycle. The loaded word has the owner in bits 31:29, the held flag in bit 28 and zeros in bits 27:0. A read strobe at any other address loads zero.
- R9: A write to the state offset or to an unmapped address has no effect on the lock.
- R10: A release write while the lock is free has no effect. The lock stays free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the lock state and the read data change on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the current address and data |
| bus_rd | input | 1 | Read strobe; the read data loads on the next rising edge |
| bus_addr | input | 4 | Byte address within the register window |
| bus_wdata | input | 32 | Write data: identifier in bits 31:29, request flag in bit 28 |
| bus_rdata | output | 32 | Registered read data |

## Verification
The claim path is exercised in three ways. A claim on a free lock must grant. A claim against a held lock, using both a foreign identifier and the owner's own identifier, must be refused. A claim without the request flag must be ignored.

The release path is exercised in four ways:
- by the owner, which must free the lock;
- by a foreign identifier;
- without the request flag;
- while the lock is free.

The last three must leave the lock untouched, and these cases separate a correct owner comparison from a release that acts on any write.

A sweep over all eight identifiers shows that identifier 0 is stored as a real owner and not mistaken for the free state. Reads and writes at the other offsets check the address decoding, and they show that the state word reads zero in all bits below bit 28.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;

    // Lock operation decoded from a bus write
    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_TAKE = 2'd1,
        LK_DROP = 2'd2
    } lk_op_e;

endpackage

// File: rtl/hwlock_decode.sv
module hwlock_decode
    import hwlock_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int ID_W     = 3,
    parameter int ACQ_OFS  = 0,
    parameter int REL_OFS  = 4,
    parameter int STAT_OFS = 8
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output lk_op_e            op,
    output logic [ID_W-1:0]   req_id,
    output logic              req_flag,
    output logic              rd_state,
    output logic              rd_any
);
    localparam int ID_LSB  = DATA_W - ID_W;
    localparam int REQ_BIT = ID_LSB - 1;
    localparam logic [ADDR_W-1:0] ACQ_A  = ADDR_W'(ACQ_OFS);
    localparam logic [ADDR_W-1:0] REL_A  = ADDR_W'(REL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic wdata_unused;
    assign wdata_unused = ^bus_wdata[REQ_BIT-1:0];

    always_comb begin
        op = LK_IDLE;
        if (bus_wr) begin
            if (bus_addr == ACQ_A)      op = LK_TAKE;
            else if (bus_addr == REL_A) op = LK_DROP;
        end
        req_id   = bus_wdata[DATA_W-1:ID_LSB];
        req_flag = bus_wdata[REQ_BIT];
        rd_state = bus_rd && (bus_addr == STAT_A);
        rd_any   = bus_rd;
    end

    // R9: only the two write offsets produce an operation
    always_comb begin
        if (bus_wr && bus_addr != ACQ_A && bus_addr != REL_A)
            dec_unmapped_idle_chk: assert (op == LK_IDLE);
    end

endmodule

// File: rtl/hwlock_owner.sv
module hwlock_owner
    import hwlock_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  lk_op_e          op,
    input  logic [ID_W-1:0] req_id,
    input  logic            req_flag,
    output logic            held,
    output logic [ID_W-1:0] owner
);
    typedef struct packed {
        logic            held;
        logic [ID_W-1:0] owner;
    } lk_state_t;

    lk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            LK_TAKE: begin
                if (req_flag && !st_q.held) begin
                    st_d.held  = 1'b1;
                    st_d.owner = req_id;
                end
            end
            LK_DROP: begin
                if (req_flag && st_q.held && req_id == st_q.owner) begin
                    st_d.held  = 1'b0;
                    st_d.owner = '0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held  = st_q.held;
    assign owner = st_q.owner;

    // R2
    grant_on_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LK_TAKE && req_flag && !st_q.held)
        |=> (st_q.held && st_q.owner == $past(req_id)));

    // R3
    held_claim_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LK_TAKE && st_q.held) |=> (st_q.held && $stable(st_q.owner)));

    // R4
    flagless_claim_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LK_TAKE && !req_flag) |=> ($stable(st_q.held) && $stable(st_q.owner)));

    // R5
    owner_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LK_DROP && req_flag && st_q.held && req_id == st_q.owner)
        |=> (!st_q.held && st_q.owner == '0));

    // R6
    foreign_release_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LK_DROP && st_q.held && (!req_flag || req_id != st_q.owner))
        |=> (st_q.held && $stable(st_q.owner)));

    // R10
    free_release_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LK_DROP && !st_q.held) |=> !st_q.held);

    // R9
    idle_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LK_IDLE) |=> ($stable(st_q.held) && $stable(st_q.owner)));

endmodule

// File: rtl/hwlock_status.sv
module hwlock_status #(
    parameter int DATA_W = 32,
    parameter int ID_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_state,
    input  logic              rd_any,
    input  logic              held,
    input  logic [ID_W-1:0]   owner,
    output logic [DATA_W-1:0] rdata
);
    localparam int ID_LSB  = DATA_W - ID_W;
    localparam int REQ_BIT = ID_LSB - 1;

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_state)    rd_d.word = {owner, held, {REQ_BIT{1'b0}}};
        else if (rd_any) rd_d.word = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q.word;

    // R8
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q.word[REQ_BIT-1:0] == '0);

    // R8
    state_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_state |=> (rd_q.word[DATA_W-1:ID_LSB] == $past(owner)
                      && rd_q.word[REQ_BIT] == $past(held)));

endmodule

// File: rtl/hwlock_reg.sv
module hwlock_reg
    import hwlock_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int ID_W     = 3,
    parameter int ACQ_OFS  = 0,
    parameter int REL_OFS  = 4,
    parameter int STAT_OFS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    lk_op_e          op;
    logic [ID_W-1:0] req_id;
    logic            req_flag;
    logic            rd_state;
    logic            rd_any;
    logic            held;
    logic [ID_W-1:0] owner;

    hwlock_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
        .ACQ_OFS(ACQ_OFS), .REL_OFS(REL_OFS), .STAT_OFS(STAT_OFS)
    ) i_decode (
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .op(op), .req_id(req_id), .req_flag(req_flag),
        .rd_state(rd_state), .rd_any(rd_any)
    );

    hwlock_owner #(.ID_W(ID_W)) i_owner (
        .clk(clk), .rst_n(rst_n), .op(op), .req_id(req_id), .req_flag(req_flag),
        .held(held), .owner(owner)
    );

    hwlock_status #(.DATA_W(DATA_W), .ID_W(ID_W)) i_status (
        .clk(clk), .rst_n(rst_n), .rd_state(rd_state), .rd_any(rd_any),
        .held(held), .owner(owner), .rdata(bus_rdata)
    );

    // R1
    reset_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!held && owner == '0));

endmodule

// File: tb/test_hwlock_reg.sv
module test_hwlock_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam logic [3:0] A_TAKE = 4'h0;
    localparam logic [3:0] A_DROP = 4'h4;
    localparam logic [3:0] A_STAT = 4'h8;
    localparam logic [3:0] A_NONE = 4'hC;

    always #5 clk = ~clk;

    hwlock_reg i_hwlock_reg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] wword(input int id, input bit flag);
        return {id[2:0], flag, 28'h0};
    endfunction

    function automatic logic [31:0] sword(input int id);
        return {id[2:0], 1'b1, 28'h0};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        bus_read(A_STAT, v);
        chk("R1 state after reset", v, 32'h0);
    endtask

    task automatic t_grant_and_contend;
        logic [31:0] v;
        bus_write(A_TAKE, wword(5, 1));
        bus_read(A_STAT, v);
        chk("R2 grant id5", v, 32'hB000_0000);
        bus_write(A_TAKE, wword(2, 1));
        bus_read(A_STAT, v);
        chk("R3 foreign claim refused", v, 32'hB000_0000);
        bus_write(A_TAKE, wword(5, 1));
        bus_read(A_STAT, v);
        chk("R3 repeat claim unchanged", v, 32'hB000_0000);
    endtask

    task automatic t_bad_release;
        logic [31:0] v;
        bus_write(A_DROP, wword(5, 0));
        bus_read(A_STAT, v);
        chk("R6 release without flag", v, 32'hB000_0000);
        bus_write(A_DROP, wword(3, 1));
        bus_read(A_STAT, v);
        chk("R6 release by non-owner", v, 32'hB000_0000);
        bus_write(A_DROP, wword(5, 1));
        bus_read(A_STAT, v);
        chk("R5 owner release frees", v, 32'h0);
    endtask

    task automatic t_flagless_claim;
        logic [31:0] v;
        bus_write(A_TAKE, wword(4, 0));
        bus_read(A_STAT, v);
        chk("R4 claim without flag ignored", v, 32'h0);
    endtask

    task automatic t_all_ids;
        logic [31:0] v;
        for (int id = 0; id < 8; id++) begin
            bus_write(A_TAKE, wword(id, 1));
            bus_read(A_STAT, v);
            chk($sformatf("R7 claim id%0d", id), v, sword(id));
            bus_write(A_DROP, wword(id, 1));
            bus_read(A_STAT, v);
            chk($sformatf("R7 release id%0d", id), v, 32'h0);
        end
    endtask

    task automatic t_offsets;
        logic [31:0] v;
        bus_write(A_TAKE, wword(1, 1));
        bus_read(A_TAKE, v);
        chk("R8 read at claim offset", v, 32'h0);
        bus_read(A_STAT, v);
        chk("R8 state word id1", v, 32'h3000_0000);
        bus_read(A_DROP, v);
        chk("R8 read at release offset", v, 32'h0);
        bus_write(A_STAT, wword(6, 1));
        bus_write(A_NONE, wword(1, 1));
        bus_read(A_STAT, v);
        chk("R9 stray writes ignored", v, 32'h3000_0000);
        bus_write(A_DROP, wword(1, 1));
        bus_write(A_STAT, wword(6, 1));
        bus_read(A_STAT, v);
        chk("R9 state offset write does not claim", v, 32'h0);
    endtask

    task automatic t_free_release;
        logic [31:0] v;
        bus_write(A_DROP, wword(0, 1));
        bus_read(A_STAT, v);
        chk("R10 release while free", v, 32'h0);
        bus_write(A_TAKE, wword(0, 1));
        bus_read(A_STAT, v);
        chk("R7 id0 held reads 10000000", v, 32'h1000_0000);
        bus_write(A_DROP, wword(0, 1));
        bus_read(A_STAT, v);
        chk("R5 id0 release", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_grant_and_contend();
        t_bad_release();
        t_flagless_claim();
        t_all_ids();
        t_offsets();
        t_free_release();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule